// File: doc/BRIEF.md
# Descriptor Program Sequencer

The sequencer is a single channel that runs a short program held in word-addressed memory. A program is a chain of descriptors. Each descriptor is one header word followed by a fixed number of operand words, and that number depends on the opcode in the header. The engine reads the header and its operands through a read-only fetch port. It then acts on a register space through a separate target port. It can merge bits into a register under a mask, jump, repeat a section with one of two loop counters, wait on a register until a masked pattern appears, and branch on such a pattern. The two data-moving opcodes and the timed-wait opcode are not executed: the engine steps past their operands and raises a sticky `unsup_o` flag.

Software starts the engine with a one-cycle `start_i` pulse that carries the program's first word address. Software can stop it at any point with `sw_stop_i`. Each header has three control bits: bit 3 pulses `irq_o` when the descriptor retires, bit 4 ends the program once the descriptor is complete, and bit 5 selects the loop counter. Software can preload the two loop counters through the `cnt_*` inputs.

States, all in `dseq_pkg::dseq_state_e`:
- IDLE: the engine waits for a start.
- FETCH_OP: the engine reads the header and notes its operand count.
- FETCH_ARG: the engine reads one operand per cycle and moves to DISPATCH after the last one.
- DISPATCH: jump and loop take effect here and move to RETIRE. An unsupported opcode sets the flag and moves to RETIRE. Write, poll and branch move to TGT_RD.
- TGT_RD: the engine reads the target register. A write goes on to TGT_WR, and a poll or branch goes on to EVAL.
- TGT_WR: the engine writes back the merged value and moves to RETIRE.
- EVAL: a poll that has not matched moves to POLL_WAIT. Every other case moves to RETIRE, and a taken branch reloads the address first.
- POLL_WAIT: the engine counts down the poll interval and then returns to TGT_RD.
- RETIRE: the interrupt fires if it was requested. The engine then moves to IDLE if the stop bit is set, or to FETCH_OP if it is not.

Software stop takes the engine from any state to IDLE.

Top module: `desc_seq_engine`

## Requirements
- R1: After reset `busy_o`, `irq_o`, `unsup_o`, `fetch_req_o` and `tgt_req_o` are all 0.
- R2: A `start_i` pulse while idle makes `busy_o` 1 on the next cycle, and the first header is fetched from `start_addr_i`. A `start_i` pulse while busy has no effect.
- R3: A write descriptor (opcode 1, operands: address, value, mask) reads the addressed register and writes back value OR (old AND NOT mask). Header bits [11:8] are not decoded.
- R4: A jump descriptor (opcode 3, operand: target) fetches the next header from the target.
- R5: A loop descriptor (opcode 4, operand: target) uses header bit 5 to select counter 0 or 1. If that counter is nonzero, the engine decrements it and continues at the target. If it is zero, the engine falls through. `cnt_load_i` preloads the counter chosen by `cnt_sel_i` with `cnt_val_i`.
- R6: A poll descriptor (opcode 5, operands: address, data, mask, interval) re-reads the register until it is satisfied, spending interval+1 idle cycles between reads. Header bit 7 set selects AND mode, in which every masked bit must equal the corresponding data bit. Bit 7 clear selects OR mode, in which at least one masked bit must equal its data bit.
- R7: A branch descriptor (opcode 6, operands: address, data, mask, target) evaluates the same match rule as a poll, with bit 7 selecting AND or OR. Type 0 in bits [10:8] jumps to the target on a match. Type 1 jumps when there is no match. Any other type never jumps.
- R8: A descriptor with header bit 3 set raises `irq_o` for exactly one cycle when it retires.
- R9: A descriptor with header bit 4 set ends the program, and `busy_o` falls after it retires. Without bit 4 the next descriptor is fetched.
- R10: `sw_stop_i` makes `busy_o` 0 on the next cycle. It raises no interrupt, and no further fetch or target access follows.
- R11: Opcodes 0, 2 and 7 skip 2, 3 and 3 operand words respectively and make no target access. They set `unsup_o`, which stays set until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| start_addr_i | input | AW | Word address of the first header |
| sw_stop_i | input | 1 | Software stop |
| cnt_load_i | input | 1 | Loop counter preload strobe |
| cnt_sel_i | input | 1 | Counter chosen for preload |
| cnt_val_i | input | CW | Preload value |
| fetch_req_o | output | 1 | Fetch read request |
| fetch_addr_o | output | AW | Fetch word address |
| fetch_rdata_i | input | 32 | Fetch data, valid in the request cycle |
| tgt_req_o | output | 1 | Target access request |
| tgt_we_o | output | 1 | Target write enable |
| tgt_addr_o | output | AW | Target address |
| tgt_wdata_o | output | 32 | Target write data |
| tgt_rdata_i | input | 32 | Target read data, valid in the request cycle |
| irq_o | output | 1 | Descriptor-complete interrupt pulse |
| busy_o | output | 1 | Program running |
| unsup_o | output | 1 | Unsupported opcode seen since start |

## Verification
An operand counter that is off by one makes every later descriptor misread. The symptom is a wrong target address or a write where none belongs, which shows at the target port within a few cycles. The unsupported-opcode test places write-like words in the skipped operand slots so that this kind of fault produces a visible write. A wrong loop counter or a wrong match polarity changes how many target accesses occur, or which path writes the flag register, and this is visible as soon as the program finishes. A stuck state shows either as `busy_o` staying high, which is caught by a per-test time limit, or as `irq_o` lasting longer than one cycle.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

    typedef enum logic [2:0] {
        OP_MOVE   = 3'd0,
        OP_WRITE  = 3'd1,
        OP_WAIT   = 3'd2,
        OP_JUMP   = 3'd3,
        OP_LOOP   = 3'd4,
        OP_POLL   = 3'd5,
        OP_BRANCH = 3'd6,
        OP_XFER   = 3'd7
    } dseq_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH_OP,
        ST_FETCH_ARG,
        ST_DISPATCH,
        ST_TGT_RD,
        ST_TGT_WR,
        ST_EVAL,
        ST_POLL_WAIT,
        ST_RETIRE
    } dseq_state_e;

    typedef struct packed {
        logic [2:0] btype;
        logic       andm;
        logic       csel;
        logic       stp;
        logic       irq;
        dseq_op_e   op;
    } dseq_hdr_t;

    localparam int MAX_ARGS = 4;
    localparam int AIW      = $clog2(MAX_ARGS);

    function automatic logic [2:0] arg_count(input logic [2:0] op);
        unique case (op)
            3'd0:                   return 3'd2;
            3'd1, 3'd2, 3'd7:       return 3'd3;
            3'd3, 3'd4:             return 3'd1;
            default:                return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dseq_match.sv
module dseq_match (
    input  logic [31:0] rd_i,
    input  logic [31:0] data_i,
    input  logic [31:0] mask_i,
    input  logic        and_mode_i,
    output logic        hit_o
);
    logic [31:0] same;

    always_comb begin
        same  = ~(rd_i ^ data_i);
        hit_o = and_mode_i ? ((~same & mask_i) == '0) : ((same & mask_i) != '0);
    end
endmodule

// File: rtl/dseq_poll_timer.sv
module dseq_poll_timer #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [PW-1:0] load_val_i,
    output logic          done_o
);
    logic [PW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load_i)         cnt_q <= load_val_i;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign done_o = (cnt_q == '0);

    AST_TMR_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R6
endmodule

// File: rtl/dseq_loop_ctrs.sv
module dseq_loop_ctrs #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          load_sel_i,
    input  logic [CW-1:0] load_val_i,
    input  logic          dec_i,
    input  logic          dec_sel_i,
    output logic          nz_o
);
    localparam int NCTR = 2;

    logic [CW-1:0] cnt_q [NCTR];
    logic [NCTR-1:0] nz;

    for (genvar g = 0; g < NCTR; g++) begin : g_ctr
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cnt_q[g] <= '0;
            else if (load_i && load_sel_i == 1'(g))
                cnt_q[g] <= load_val_i;
            else if (dec_i && dec_sel_i == 1'(g))
                cnt_q[g] <= cnt_q[g] - 1'b1;
        end
        assign nz[g] = (cnt_q[g] != '0);

        AST_CTR_DEC: assert property (@(posedge clk) disable iff (!rst_n)
            (dec_i && dec_sel_i == 1'(g) && !load_i) |=> (cnt_q[g] == $past(cnt_q[g]) - 1'b1)); // R5
        AST_CTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!load_i && !(dec_i && dec_sel_i == 1'(g))) |=> $stable(cnt_q[g])); // R5
    end

    assign nz_o = nz[dec_sel_i];
endmodule

// File: rtl/desc_seq_engine.sv
module desc_seq_engine
    import dseq_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] start_addr_i,
    input  logic          sw_stop_i,
    input  logic          cnt_load_i,
    input  logic          cnt_sel_i,
    input  logic [CW-1:0] cnt_val_i,
    output logic          fetch_req_o,
    output logic [AW-1:0] fetch_addr_o,
    input  logic [31:0]   fetch_rdata_i,
    output logic          tgt_req_o,
    output logic          tgt_we_o,
    output logic [AW-1:0] tgt_addr_o,
    output logic [31:0]   tgt_wdata_o,
    input  logic [31:0]   tgt_rdata_i,
    output logic          irq_o,
    output logic          busy_o,
    output logic          unsup_o
);
    dseq_state_e   state_q, state_d;
    dseq_hdr_t     hdr_q;
    logic [AW-1:0] pc_q;
    logic [31:0]   args_q [MAX_ARGS];
    logic [AIW-1:0] aidx_q;
    logic [2:0]    nargs_q;
    logic [31:0]   rd_q;
    logic          unsup_q;

    logic          hit, ctr_nz, tmr_done, br_taken, loop_take, last_arg;

    dseq_match u_match (
        .rd_i       (rd_q),
        .data_i     (args_q[1]),
        .mask_i     (args_q[2]),
        .and_mode_i (hdr_q.andm),
        .hit_o      (hit)
    );

    dseq_loop_ctrs #(.CW(CW)) u_ctrs (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (cnt_load_i),
        .load_sel_i (cnt_sel_i),
        .load_val_i (cnt_val_i),
        .dec_i      (loop_take && !sw_stop_i),
        .dec_sel_i  (hdr_q.csel),
        .nz_o       (ctr_nz)
    );

    dseq_poll_timer #(.PW(PW)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (state_q == ST_EVAL && hdr_q.op == OP_POLL),
        .load_val_i (args_q[3][PW-1:0]),
        .done_o     (tmr_done)
    );

    always_comb begin
        loop_take = (state_q == ST_DISPATCH) && (hdr_q.op == OP_LOOP) && ctr_nz;
        last_arg  = ({1'b0, aidx_q} == (nargs_q - 3'd1));
        unique case (hdr_q.btype)
            3'd0:    br_taken = hit;
            3'd1:    br_taken = !hit;
            default: br_taken = 1'b0;
        endcase
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start_i) state_d = ST_FETCH_OP;
            ST_FETCH_OP:  state_d = ST_FETCH_ARG;
            ST_FETCH_ARG: if (last_arg) state_d = ST_DISPATCH;
            ST_DISPATCH: begin
                unique case (hdr_q.op)
                    OP_WRITE, OP_POLL, OP_BRANCH: state_d = ST_TGT_RD;
                    default:                      state_d = ST_RETIRE;
                endcase
            end
            ST_TGT_RD:    state_d = (hdr_q.op == OP_WRITE) ? ST_TGT_WR : ST_EVAL;
            ST_TGT_WR:    state_d = ST_RETIRE;
            ST_EVAL:      state_d = (hdr_q.op == OP_POLL && !hit) ? ST_POLL_WAIT : ST_RETIRE;
            ST_POLL_WAIT: if (tmr_done) state_d = ST_TGT_RD;
            ST_RETIRE:    state_d = hdr_q.stp ? ST_IDLE : ST_FETCH_OP;
            default:      state_d = ST_IDLE;
        endcase
        if (sw_stop_i) state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_q   <= '0;
            pc_q    <= '0;
            aidx_q  <= '0;
            nargs_q <= '0;
            rd_q    <= '0;
            unsup_q <= 1'b0;
            for (int i = 0; i < MAX_ARGS; i++) args_q[i] <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i && !sw_stop_i) begin
                        pc_q    <= start_addr_i;
                        unsup_q <= 1'b0;
                    end
                end
                ST_FETCH_OP: begin
                    hdr_q.op    <= dseq_op_e'(fetch_rdata_i[2:0]);
                    hdr_q.irq   <= fetch_rdata_i[3];
                    hdr_q.stp   <= fetch_rdata_i[4];
                    hdr_q.csel  <= fetch_rdata_i[5];
                    hdr_q.andm  <= fetch_rdata_i[7];
                    hdr_q.btype <= fetch_rdata_i[10:8];
                    nargs_q     <= arg_count(fetch_rdata_i[2:0]);
                    aidx_q      <= '0;
                    pc_q        <= pc_q + 1'b1;
                end
                ST_FETCH_ARG: begin
                    args_q[aidx_q] <= fetch_rdata_i;
                    aidx_q         <= aidx_q + 1'b1;
                    pc_q           <= pc_q + 1'b1;
                end
                ST_DISPATCH: begin
                    unique case (hdr_q.op)
                        OP_JUMP:                  pc_q <= args_q[0][AW-1:0];
                        OP_LOOP:                  if (ctr_nz) pc_q <= args_q[0][AW-1:0];
                        OP_MOVE, OP_WAIT, OP_XFER: unsup_q <= 1'b1;
                        default: ;
                    endcase
                end
                ST_TGT_RD: rd_q <= tgt_rdata_i;
                ST_EVAL:   if (hdr_q.op == OP_BRANCH && br_taken) pc_q <= args_q[3][AW-1:0];
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        fetch_req_o  = (state_q == ST_FETCH_OP) || (state_q == ST_FETCH_ARG);
        fetch_addr_o = pc_q;
        tgt_req_o    = ((state_q == ST_TGT_RD) || (state_q == ST_TGT_WR)) && !sw_stop_i;
        tgt_we_o     = (state_q == ST_TGT_WR);
        tgt_addr_o   = args_q[0][AW-1:0];
        tgt_wdata_o  = args_q[1] | (rd_q & ~args_q[2]);
        irq_o        = (state_q == ST_RETIRE) && hdr_q.irq && !sw_stop_i;
        busy_o       = (state_q != ST_IDLE);
        unsup_o      = unsup_q;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !(fetch_req_o || tgt_req_o)); // R1
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !sw_stop_i) |=> busy_o); // R2
    AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_req_o && tgt_we_o) |-> $past(tgt_req_o && !tgt_we_o)); // R3
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o); // R8
    AST_IRQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> busy_o); // R8
    AST_SW_STOP_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        sw_stop_i |=> !busy_o); // R10
endmodule

// File: tb/tb_desc_seq_engine.sv
`timescale 1ns/1ps
module tb_desc_seq_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] start_addr_i = '0;
    logic        sw_stop_i = 1'b0;
    logic        cnt_load_i = 1'b0;
    logic        cnt_sel_i = 1'b0;
    logic [15:0] cnt_val_i = '0;
    logic        fetch_req_o, tgt_req_o, tgt_we_o, irq_o, busy_o, unsup_o;
    logic [31:0] fetch_addr_o, tgt_addr_o, tgt_wdata_o, fetch_rdata_i, tgt_rdata_i;

    logic [31:0] mem [256];
    logic [31:0] treg [16];
    int          wr_cnt [16];
    int          rd_cnt [16];
    int          irq_hi, irq_pulses;
    logic        irq_prev;
    logic        poke_en = 1'b0, clr = 1'b0;
    logic [3:0]  poke_a = '0;
    logic [31:0] poke_v = '0;
    int          n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    desc_seq_engine dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
        .sw_stop_i(sw_stop_i), .cnt_load_i(cnt_load_i), .cnt_sel_i(cnt_sel_i),
        .cnt_val_i(cnt_val_i), .fetch_req_o(fetch_req_o), .fetch_addr_o(fetch_addr_o),
        .fetch_rdata_i(fetch_rdata_i), .tgt_req_o(tgt_req_o), .tgt_we_o(tgt_we_o),
        .tgt_addr_o(tgt_addr_o), .tgt_wdata_o(tgt_wdata_o), .tgt_rdata_i(tgt_rdata_i),
        .irq_o(irq_o), .busy_o(busy_o), .unsup_o(unsup_o)
    );

    assign fetch_rdata_i = mem[fetch_addr_o[7:0]];
    assign tgt_rdata_i   = treg[tgt_addr_o[3:0]];

    always @(posedge clk) begin
        if (clr) begin
            for (int i = 0; i < 16; i++) begin wr_cnt[i] <= 0; rd_cnt[i] <= 0; end
            irq_hi <= 0; irq_pulses <= 0; irq_prev <= 1'b0;
        end else begin
            irq_prev <= irq_o;
            if (irq_o) irq_hi <= irq_hi + 1;
            if (irq_o && !irq_prev) irq_pulses <= irq_pulses + 1;
            if (tgt_req_o && !tgt_we_o) rd_cnt[tgt_addr_o[3:0]] <= rd_cnt[tgt_addr_o[3:0]] + 1;
            if (tgt_req_o && tgt_we_o) wr_cnt[tgt_addr_o[3:0]] <= wr_cnt[tgt_addr_o[3:0]] + 1;
        end
        if (poke_en) treg[poke_a] <= poke_v;
        else if (tgt_req_o && tgt_we_o) treg[tgt_addr_o[3:0]] <= tgt_wdata_o;
    end

    function automatic logic [31:0] opw(input int op, input bit irq, input bit stp, input logic [31:0] extra);
        return extra | (32'(stp) << 4) | (32'(irq) << 3) | 32'(op);
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic poke(input int a, input logic [31:0] v);
        @(negedge clk); poke_en = 1'b1; poke_a = 4'(a); poke_v = v;
        @(negedge clk); poke_en = 1'b0;
    endtask

    task automatic clear_stats();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic go(input int a);
        @(negedge clk); start_i = 1'b1; start_addr_i = 32'(a);
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int k = 0;
        while (busy_o && k < 2000) begin @(negedge clk); k++; end
        check(req, "program finished", 32'(busy_o), 32'd0);
    endtask

    task automatic load_ctr(input bit sel, input int v);
        @(negedge clk); cnt_load_i = 1'b1; cnt_sel_i = sel; cnt_val_i = 16'(v);
        @(negedge clk); cnt_load_i = 1'b0;
    endtask

    task automatic wrdesc(input int at, input bit irq, input bit stp, input int reg_a, input logic [31:0] v, input logic [31:0] m);
        mem[at] = opw(1, irq, stp, 32'h0000_0A00); // write method bits present, not decoded (R3)
        mem[at+1] = 32'(reg_a); mem[at+2] = v; mem[at+3] = m;
    endtask

    task automatic t_reset();
        check("R1", "busy", 32'(busy_o), 0);
        check("R1", "irq", 32'(irq_o), 0);
        check("R1", "unsup", 32'(unsup_o), 0);
        check("R1", "fetch_req", 32'(fetch_req_o), 0);
        check("R1", "tgt_req", 32'(tgt_req_o), 0);
    endtask

    task automatic t_write();
        wrdesc(0, 0, 1, 3, 32'h0000_00A5, 32'h0000_00FF);
        wrdesc(8, 0, 1, 4, 32'hF000_0000, 32'hF0F0_0000);
        poke(3, 32'h1234_5678); poke(4, 32'hFFFF_FFFF);
        clear_stats();
        go(0);
        check("R2", "busy after start", 32'(busy_o), 1);
        wait_idle("R9");
        check("R3", "merge low byte", treg[3], 32'h1234_56A5);
        check("R9", "no irq without bit3", 32'(irq_hi), 0);
        go(8); wait_idle("R9");
        check("R3", "merge upper nibbles", treg[4], 32'hFF0F_FFFF);
    endtask

    task automatic t_jump();
        mem[16] = opw(3, 0, 0, 0); mem[17] = 40;
        wrdesc(18, 0, 1, 6, 32'h22, 32'hFFFF_FFFF);
        wrdesc(40, 0, 1, 5, 32'h11, 32'hFFFF_FFFF);
        poke(5, 0); poke(6, 0);
        go(16); wait_idle("R4");
        check("R4", "target path written", treg[5], 32'h11);
        check("R4", "skipped path untouched", treg[6], 32'h0);
    endtask

    task automatic t_loop();
        wrdesc(48, 0, 0, 7, 0, 0);
        mem[52] = opw(4, 0, 0, 32'h20); mem[53] = 48;
        wrdesc(54, 0, 1, 8, 32'h99, 32'hFFFF_FFFF);
        wrdesc(60, 0, 0, 7, 0, 0);
        mem[64] = opw(4, 0, 0, 0); mem[65] = 60;
        wrdesc(66, 0, 1, 8, 32'h98, 32'hFFFF_FFFF);
        load_ctr(0, 2); load_ctr(1, 3);
        clear_stats(); go(48); wait_idle("R5");
        check("R5", "counter1 passes", 32'(wr_cnt[7]), 4);
        check("R9", "continued past non-stop write", treg[8], 32'h99);
        clear_stats(); go(60); wait_idle("R5");
        check("R5", "counter0 passes", 32'(wr_cnt[7]), 3);
        clear_stats(); go(48); wait_idle("R5");
        check("R5", "counter1 exhausted falls through", 32'(wr_cnt[7]), 1);
    endtask

    task automatic t_poll();
        mem[70] = opw(5, 0, 0, 32'h80); mem[71] = 9; mem[72] = 5; mem[73] = 32'hF; mem[74] = 3;
        wrdesc(75, 0, 1, 10, 32'h77, 32'hFFFF_FFFF);
        poke(9, 32'h10); poke(10, 0);
        clear_stats(); go(70);
        repeat (30) @(negedge clk);
        check("R6", "AND poll still waiting", 32'(busy_o), 1);
        check("R6", "no write before match", treg[10], 0);
        check("R6", "re-read count in range", 32'(rd_cnt[9] >= 3 && rd_cnt[9] <= 6), 1);
        poke(9, 32'h7);
        repeat (15) @(negedge clk);
        check("R6", "AND poll partial match waits", 32'(busy_o), 1);
        poke(9, 32'hF5);
        wait_idle("R6");
        check("R6", "AND poll satisfied", treg[10], 32'h77);
        mem[80] = opw(5, 0, 0, 0); mem[81] = 11; mem[82] = 3; mem[83] = 3; mem[84] = 0;
        wrdesc(85, 0, 1, 10, 32'h66, 32'hFFFF_FFFF);
        poke(11, 32'h0);
        go(80);
        repeat (20) @(negedge clk);
        check("R6", "OR poll no bit matches waits", 32'(busy_o), 1);
        poke(11, 32'h1);
        wait_idle("R6");
        check("R6", "OR poll one bit matches", treg[10], 32'h66);
    endtask

    task automatic branch_case(input bit andm, input int typ, input logic [31:0] v, input logic [31:0] exp);
        mem[100] = opw(6, 0, 0, (andm ? 32'h80 : 32'h0) | (32'(typ) << 8));
        mem[101] = 12; mem[102] = 32'hA; mem[103] = 32'hF; mem[104] = 120;
        wrdesc(105, 0, 1, 13, 1, 32'hFFFF_FFFF);
        wrdesc(120, 0, 1, 13, 2, 32'hFFFF_FFFF);
        poke(12, v); poke(13, 0);
        go(100); wait_idle("R7");
        check("R7", $sformatf("branch and=%0d type=%0d val=%h", andm, typ, v), treg[13], exp);
    endtask

    task automatic t_branch();
        branch_case(1, 0, 32'hA, 2);
        branch_case(1, 0, 32'hB, 1);
        branch_case(1, 1, 32'hB, 2);
        branch_case(1, 1, 32'hA, 1);
        branch_case(1, 3, 32'hA, 1);
        branch_case(0, 0, 32'hB, 2);
        branch_case(0, 0, 32'h5, 1);
    endtask

    task automatic t_irq();
        mem[130] = opw(3, 1, 0, 0); mem[131] = 140;
        mem[140] = opw(1, 1, 1, 0); mem[141] = 14; mem[142] = 0; mem[143] = 0;
        clear_stats(); go(130); wait_idle("R8");
        check("R8", "irq pulses", 32'(irq_pulses), 2);
        check("R8", "irq high cycles", 32'(irq_hi), 2);
    endtask

    task automatic t_swstop();
        int rd_before;
        mem[150] = opw(5, 1, 0, 32'h80); mem[151] = 15; mem[152] = 1; mem[153] = 1; mem[154] = 2;
        poke(15, 0);
        clear_stats(); go(150);
        repeat (15) @(negedge clk);
        go(0);
        repeat (5) @(negedge clk);
        sw_stop_i = 1'b1;
        @(negedge clk); sw_stop_i = 1'b0;
        check("R10", "busy after stop", 32'(busy_o), 0);
        rd_before = rd_cnt[15];
        repeat (20) @(negedge clk);
        check("R10", "no reads after stop", 32'(rd_cnt[15]), 32'(rd_before));
        check("R10", "no irq on stop", 32'(irq_hi), 0);
        check("R2", "start while busy ignored", 32'(wr_cnt[3]), 0);
        check("R10", "no fetch after stop", 32'(fetch_req_o), 0);
    endtask

    task automatic t_unsup();
        int tot;
        mem[160] = opw(0, 0, 0, 0); mem[161] = opw(1, 0, 1, 0); mem[162] = opw(1, 0, 1, 0);
        mem[163] = opw(2, 0, 0, 0);
        for (int i = 164; i < 167; i++) mem[i] = opw(1, 0, 1, 0);
        mem[167] = opw(7, 0, 0, 0);
        for (int i = 168; i < 171; i++) mem[i] = opw(1, 0, 1, 0);
        wrdesc(171, 0, 1, 14, 32'h5A, 32'hFFFF_FFFF);
        poke(14, 0);
        clear_stats(); go(160); wait_idle("R11");
        tot = 0;
        for (int i = 0; i < 16; i++) tot += wr_cnt[i] + rd_cnt[i];
        check("R11", "final write landed", treg[14], 32'h5A);
        check("R11", "only that write's accesses", 32'(tot), 2);
        check("R11", "flag set", 32'(unsup_o), 1);
        go(0); wait_idle("R11");
        check("R11", "flag cleared by start", 32'(unsup_o), 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        for (int i = 0; i < 16; i++) treg[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write();
        t_jump();
        t_loop();
        t_poll();
        t_branch();
        t_irq();
        t_swstop();
        t_unsup();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad + 1);
        $finish;
    end
endmodule